// File: doc/BRIEF.md
# Gapless Page-Burst Command Sequencer for Paired SDRAM Devices

This block produces an endless SDRAM command stream that keeps two memory devices streaming full-page bursts with no idle columns between pages. One device, the command device, is read continuously. The other, the capture device, is written continuously with sampled data. A column counter advances once per clock through a page. At fixed positions in each page the block precharges the bank that has just been used, opens the next bank's row, and starts the next full-page burst. Because the next bank is opened while the current page is still bursting, the data of consecutive pages runs back to back.

The block never issues refresh commands. Every row is kept alive because the walk activates and precharges each row of every bank in turn, on both devices in lockstep. When capture is switched off, the capture device's write is suppressed by deasserting its chip select. Activates and precharges continue, so the capture device is still refreshed. The CAS latency and the activate-to-command delay are taken from inputs at start. After start the block primes the first page with an activate and a burst, then runs the steady schedule forever.

Top module: `page_stream_seq`

## Requirements
- R1: After reset, and until start is seen, both ports drive NOP, {CS_n,RAS_n,CAS_n,WE_n} = 0111, with bank 0 and address 0.
- R2: In the first cycle after start is sampled while idle, both ports drive ACTIVE (0011) to bank 0 with row 0 on the address. CAS latency (2 or 3) and activate delay (1 to 3) are captured at that edge.
- R3: The activate delay after each activate, the command port drives READ (0101) to the activated bank with address 0 and the capture port drives NOP. The capture port never drives READ.
- R4: One cycle before each page start (CAS latency − 1 cycles after the READ), the capture port drives WRITE (0100) to the same bank with address 0 and the command port drives NOP. The command port never drives WRITE.
- R5: At column 0 of every page, both ports drive PRECHARGE (0010) with address 0 (A10 low, single bank) to the bank of the previous page.
- R6: Each page's ACTIVE is issued on both ports at column COLS − CL − tRCD of the preceding page, CL + tRCD cycles before that page's column 0, with identical bank and row.
- R7: Consecutive READ commands on the command port are exactly COLS cycles apart.
- R8: The activated bank steps by one modulo BANKS per page. The row steps by one each time the bank returns to 0, and it wraps from NUM_ROWS − 1 to 0.
- R9: With capture disabled in the write cycle, the capture port drives 1100 (chip select high, write suppressed) with the write's bank and address. Precharge and activate are still issued to both ports.
- R10: In every cycle not named above, both ports drive NOP (0111) with bank 0 and address 0.
- R11: Start asserted while running is ignored. Changes to the latency inputs after start do not alter the schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin the free-running schedule (taken only while idle) |
| cap_en_i | input | 1 | Capture enable, sampled in the write cycle |
| cas_lat_i | input | 2 | CAS latency, 2 or 3 |
| act_dly_i | input | 2 | Activate-to-burst delay, 1 to 3 |
| cmd_cs_n_o | output | 1 | Command port chip select, active low |
| cmd_ras_n_o | output | 1 | Command port RAS, active low |
| cmd_cas_n_o | output | 1 | Command port CAS, active low |
| cmd_we_n_o | output | 1 | Command port write enable, active low |
| cmd_ba_o | output | BANK_W | Command port bank |
| cmd_addr_o | output | ADDR_W | Command port address |
| cap_cs_n_o | output | 1 | Capture port chip select, active low |
| cap_ras_n_o | output | 1 | Capture port RAS, active low |
| cap_cas_n_o | output | 1 | Capture port CAS, active low |
| cap_we_n_o | output | 1 | Capture port write enable, active low |
| cap_ba_o | output | BANK_W | Capture port bank |
| cap_addr_o | output | ADDR_W | Capture port address |

## Verification
The bench compares both ports cycle by cycle against an independent model of the page schedule over several latency and delay pairs. Those pairs move the activate and read columns. A design that put the priming activate at a fixed offset, or let read and write collide, would show the wrong command in the first page. Runs long enough to wrap both the bank and the row counters would expose an off-by-one in the row wrap or a precharge aimed at the wrong bank. Capture is turned off and toggled per page to catch a design that drops the refresh activates along with the write. Start pulses and latency changes while running would show up as a restarted or shifted schedule.

// File: rtl/pws_pkg.sv
`timescale 1ns/1ps
// Shared command encodings and schedule slot type for the page stream
// sequencer. Commands are packed {CS_n, RAS_n, CAS_n, WE_n}.
package pws_pkg;

    typedef logic [3:0] sd_cmd_t;

    localparam sd_cmd_t CMD_NOP  = 4'b0111;
    localparam sd_cmd_t CMD_ACT  = 4'b0011;
    localparam sd_cmd_t CMD_RD   = 4'b0101;
    localparam sd_cmd_t CMD_WR   = 4'b0100;
    localparam sd_cmd_t CMD_PRE  = 4'b0010;
    localparam sd_cmd_t CMD_WR_X = 4'b1100;  // write with chip select held high

    // What the current column of the page calls for.
    typedef enum logic [2:0] {
        SLOT_NOP = 3'd0,
        SLOT_PRE = 3'd1,
        SLOT_ACT = 3'd2,
        SLOT_RD  = 3'd3,
        SLOT_WR  = 3'd4
    } slot_e;

endpackage

// File: rtl/pws_col_sched.sv
`timescale 1ns/1ps
// Column timer and schedule decoder.
// Holds the run flag, the column within the current page and the latencies
// captured at start. Decodes which command slot the present column holds.
// Assumes cl in {2,3}, rcd in {1..3} and COLS >= CL+tRCD+2, so that the
// precharge, activate, read and write columns are all distinct.
// Start loads the column to the activate position of a virtual page -1,
// so priming falls out of the steady schedule.
module pws_col_sched
    import pws_pkg::*;
#(
    parameter int COLS  = 1024,
    parameter int TIM_W = 2,
    localparam int COL_W = $clog2(COLS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [TIM_W-1:0] cl_i,
    input  logic [TIM_W-1:0] rcd_i,
    output logic             running_o,
    output logic             load_o,
    output logic             page_end_o,
    output slot_e            slot_o
);

    logic             running_q;
    logic [COL_W-1:0] col_q;
    logic [TIM_W-1:0] cl_q;
    logic [TIM_W-1:0] rcd_q;
    logic [COL_W-1:0] act_col;
    logic [COL_W-1:0] rd_col;
    logic [COL_W-1:0] last_col;
    logic [COL_W-1:0] load_col;

    // Start is honoured only while idle.
    assign load_o   = start_i && !running_q;
    assign last_col = COL_W'(COLS - 1);

    // Positions of activate, read and starting column, from latencies.
    always_comb begin
        act_col  = COL_W'(COLS - int'(cl_q) - int'(rcd_q));
        rd_col   = COL_W'(COLS - int'(cl_q));
        load_col = COL_W'(COLS - int'(cl_i) - int'(rcd_i));
    end

    // Run flag, latency capture and column counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            col_q     <= '0;
            cl_q      <= TIM_W'(2);
            rcd_q     <= TIM_W'(1);
        end else if (load_o) begin
            running_q <= 1'b1;
            cl_q      <= cl_i;
            rcd_q     <= rcd_i;
            col_q     <= load_col;
        end else if (running_q) begin
            col_q <= (col_q == last_col) ? '0 : col_q + 1'b1;
        end
    end

    // Slot decode for the present column.
    always_comb begin
        if (!running_q)                slot_o = SLOT_NOP;
        else if (col_q == '0)          slot_o = SLOT_PRE;
        else if (col_q == act_col)     slot_o = SLOT_ACT;
        else if (col_q == rd_col)      slot_o = SLOT_RD;
        else if (col_q == last_col)    slot_o = SLOT_WR;
        else                           slot_o = SLOT_NOP;
    end

    assign running_o  = running_q;
    assign page_end_o = running_q && (col_q == last_col);

endmodule

// File: rtl/pws_page_trk.sv
`timescale 1ns/1ps
// Page tracker: bank and row of the page in progress.
// Supplies the next page's bank and row (target of activate and bursts) and
// the previous page's bank (target of precharge). Reset and start place it
// on a virtual page -1 (last bank, last row) so the first page is bank 0,
// row 0. Assumes BANKS >= 2 and NUM_ROWS <= 2**ROW_W.
module pws_page_trk #(
    parameter int BANKS    = 4,
    parameter int NUM_ROWS = 8192,
    parameter int ROW_W    = 13,
    localparam int BANK_W  = $clog2(BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              adv_i,
    output logic [BANK_W-1:0] nxt_bank_o,
    output logic [ROW_W-1:0]  nxt_row_o,
    output logic [BANK_W-1:0] prv_bank_o
);

    localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(BANKS - 1);
    localparam logic [ROW_W-1:0]  LAST_ROW  = ROW_W'(NUM_ROWS - 1);

    logic [BANK_W-1:0] cur_bank_q;
    logic [ROW_W-1:0]  cur_row_q;

    // Successor and predecessor of the current page.
    always_comb begin
        nxt_bank_o = (cur_bank_q == LAST_BANK) ? '0 : cur_bank_q + 1'b1;
        if (nxt_bank_o == '0)
            nxt_row_o = (cur_row_q == LAST_ROW) ? '0 : cur_row_q + 1'b1;
        else
            nxt_row_o = cur_row_q;
        prv_bank_o = (cur_bank_q == '0) ? LAST_BANK : cur_bank_q - 1'b1;
    end

    // Step to the next page at each page end; rewind on reset or start.
    always_ff @(posedge clk) begin
        if (!rst_n || load_i) begin
            cur_bank_q <= LAST_BANK;
            cur_row_q  <= LAST_ROW;
        end else if (adv_i) begin
            cur_bank_q <= nxt_bank_o;
            cur_row_q  <= nxt_row_o;
        end
    end

endmodule

// File: rtl/pws_port_drv.sv
`timescale 1ns/1ps
// Port encoder: turns the schedule slot into one device's command, bank
// and address. IS_CAPTURE selects the variant: the command device takes
// reads and ignores the write slot; the capture device takes writes,
// ignores the read slot and holds chip select high when capture is off.
// Both variants take precharge and activate.
module pws_port_drv
    import pws_pkg::*;
#(
    parameter bit IS_CAPTURE = 1'b0,
    parameter int BANK_W     = 2,
    parameter int ROW_W      = 13,
    parameter int ADDR_W     = 13
) (
    input  slot_e             slot_i,
    input  logic              cap_en_i,
    input  logic [BANK_W-1:0] nxt_bank_i,
    input  logic [ROW_W-1:0]  nxt_row_i,
    input  logic [BANK_W-1:0] prv_bank_i,
    output sd_cmd_t           cmd_o,
    output logic [BANK_W-1:0] ba_o,
    output logic [ADDR_W-1:0] addr_o
);

    // Command, bank and address for this device in this column.
    always_comb begin
        cmd_o  = CMD_NOP;
        ba_o   = '0;
        addr_o = '0;
        unique case (slot_i)
            SLOT_PRE: begin
                cmd_o = CMD_PRE;
                ba_o  = prv_bank_i;
            end
            SLOT_ACT: begin
                cmd_o               = CMD_ACT;
                ba_o                = nxt_bank_i;
                addr_o[ROW_W-1:0]   = nxt_row_i;
            end
            SLOT_RD: begin
                if (!IS_CAPTURE) begin
                    cmd_o = CMD_RD;
                    ba_o  = nxt_bank_i;
                end
            end
            SLOT_WR: begin
                if (IS_CAPTURE) begin
                    cmd_o = cap_en_i ? CMD_WR : CMD_WR_X;
                    ba_o  = nxt_bank_i;
                end
            end
            default: begin
                cmd_o = CMD_NOP;
            end
        endcase
    end

endmodule

// File: rtl/page_stream_seq.sv
`timescale 1ns/1ps
// Free-running page-interleave command sequencer for two SDRAM devices.
// Once started it walks every bank and row forever: precharge at column 0,
// activate of the next bank CL+tRCD before the page end, read (command
// device) CL before the page end and write (capture device) on the last
// column, so bursts of consecutive pages abut. No refresh commands are
// issued; the activate/precharge walk keeps rows alive. Outputs are decoded
// directly from registered state. Assumes ADDR_W >= ROW_W.
module page_stream_seq
    import pws_pkg::*;
#(
    parameter int COLS     = 1024,
    parameter int BANKS    = 4,
    parameter int ROW_W    = 13,
    parameter int NUM_ROWS = 8192,
    parameter int ADDR_W   = 13,
    parameter int TIM_W    = 2,
    localparam int BANK_W  = $clog2(BANKS),
    localparam int NPORT   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cap_en_i,
    input  logic [TIM_W-1:0]  cas_lat_i,
    input  logic [TIM_W-1:0]  act_dly_i,
    output logic              cmd_cs_n_o,
    output logic              cmd_ras_n_o,
    output logic              cmd_cas_n_o,
    output logic              cmd_we_n_o,
    output logic [BANK_W-1:0] cmd_ba_o,
    output logic [ADDR_W-1:0] cmd_addr_o,
    output logic              cap_cs_n_o,
    output logic              cap_ras_n_o,
    output logic              cap_cas_n_o,
    output logic              cap_we_n_o,
    output logic [BANK_W-1:0] cap_ba_o,
    output logic [ADDR_W-1:0] cap_addr_o
);

    logic              running;
    logic              load;
    logic              page_end;
    slot_e             slot;
    logic [BANK_W-1:0] nxt_bank;
    logic [ROW_W-1:0]  nxt_row;
    logic [BANK_W-1:0] prv_bank;

    sd_cmd_t           port_cmd  [NPORT];
    logic [BANK_W-1:0] port_ba   [NPORT];
    logic [ADDR_W-1:0] port_addr [NPORT];

    pws_col_sched #(
        .COLS  (COLS),
        .TIM_W (TIM_W)
    ) u_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .cl_i       (cas_lat_i),
        .rcd_i      (act_dly_i),
        .running_o  (running),
        .load_o     (load),
        .page_end_o (page_end),
        .slot_o     (slot)
    );

    pws_page_trk #(
        .BANKS    (BANKS),
        .NUM_ROWS (NUM_ROWS),
        .ROW_W    (ROW_W)
    ) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .adv_i      (page_end),
        .nxt_bank_o (nxt_bank),
        .nxt_row_o  (nxt_row),
        .prv_bank_o (prv_bank)
    );

    // Port 0 is the command device, port 1 the capture device.
    for (genvar g = 0; g < NPORT; g++) begin : g_port
        pws_port_drv #(
            .IS_CAPTURE (g == 1),
            .BANK_W     (BANK_W),
            .ROW_W      (ROW_W),
            .ADDR_W     (ADDR_W)
        ) u_drv (
            .slot_i     (slot),
            .cap_en_i   (cap_en_i),
            .nxt_bank_i (nxt_bank),
            .nxt_row_i  (nxt_row),
            .prv_bank_i (prv_bank),
            .cmd_o      (port_cmd[g]),
            .ba_o       (port_ba[g]),
            .addr_o     (port_addr[g])
        );
    end

    assign {cmd_cs_n_o, cmd_ras_n_o, cmd_cas_n_o, cmd_we_n_o} = port_cmd[0];
    assign cmd_ba_o   = port_ba[0];
    assign cmd_addr_o = port_addr[0];
    assign {cap_cs_n_o, cap_ras_n_o, cap_cas_n_o, cap_we_n_o} = port_cmd[1];
    assign cap_ba_o   = port_ba[1];
    assign cap_addr_o = port_addr[1];

    logic unused_running;
    assign unused_running = running;

endmodule

// File: rtl/page_stream_seq_chk.sv
`timescale 1ns/1ps
// Checker for page_stream_seq, attached by bind. Observes only the ports
// and keeps its own history of activate banks and read spacing.
module page_stream_seq_chk
    import pws_pkg::*;
#(
    parameter int COLS   = 1024,
    parameter int BANKS  = 4,
    parameter int BANK_W = 2,
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cap_en_i,
    input logic              cmd_cs_n_o,
    input logic              cmd_ras_n_o,
    input logic              cmd_cas_n_o,
    input logic              cmd_we_n_o,
    input logic [BANK_W-1:0] cmd_ba_o,
    input logic [ADDR_W-1:0] cmd_addr_o,
    input logic              cap_cs_n_o,
    input logic              cap_ras_n_o,
    input logic              cap_cas_n_o,
    input logic              cap_we_n_o,
    input logic [BANK_W-1:0] cap_ba_o,
    input logic [ADDR_W-1:0] cap_addr_o
);

    sd_cmd_t           c_cmd;
    sd_cmd_t           k_cmd;
    logic [BANK_W-1:0] last_act_q;
    logic              act_seen_q;
    int unsigned       rd_gap_q;
    logic              rd_seen_q;

    assign c_cmd = {cmd_cs_n_o, cmd_ras_n_o, cmd_cas_n_o, cmd_we_n_o};
    assign k_cmd = {cap_cs_n_o, cap_ras_n_o, cap_cas_n_o, cap_we_n_o};

    // History: bank of the last activate and cycles since the last read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_act_q <= '0;
            act_seen_q <= 1'b0;
            rd_gap_q   <= 0;
            rd_seen_q  <= 1'b0;
        end else begin
            if (c_cmd == CMD_ACT) begin
                last_act_q <= cmd_ba_o;
                act_seen_q <= 1'b1;
            end
            if (c_cmd == CMD_RD) begin
                rd_gap_q  <= 1;
                rd_seen_q <= 1'b1;
            end else if (rd_seen_q) begin
                rd_gap_q <= rd_gap_q + 1;
            end
        end
    end

    AST_PRE_LOCKSTEP: assert property (@(posedge clk) disable iff (!rst_n)
        (c_cmd == CMD_PRE) |-> (k_cmd == CMD_PRE && cap_ba_o == cmd_ba_o && cmd_addr_o == '0)); // R5

    AST_PRE_PREV_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (c_cmd == CMD_PRE && act_seen_q) |-> (int'(cmd_ba_o) == (int'(last_act_q) + BANKS - 1) % BANKS)); // R5

    AST_ACT_LOCKSTEP: assert property (@(posedge clk) disable iff (!rst_n)
        (c_cmd == CMD_ACT) |-> (k_cmd == CMD_ACT && cap_ba_o == cmd_ba_o && cap_addr_o == cmd_addr_o)); // R6

    AST_ACT_BANK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (c_cmd == CMD_ACT && act_seen_q) |-> (int'(cmd_ba_o) == (int'(last_act_q) + 1) % BANKS)); // R8

    AST_READ_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (c_cmd == CMD_RD && rd_seen_q) |-> (rd_gap_q == COLS)); // R7

    AST_CAP_NEVER_READS: assert property (@(posedge clk) disable iff (!rst_n)
        (k_cmd != CMD_RD)); // R3

    AST_CMD_NEVER_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (c_cmd != CMD_WR && c_cmd != CMD_WR_X)); // R4

    AST_READ_THEN_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (c_cmd == CMD_RD) |=> (c_cmd == CMD_NOP)); // R10

    AST_DESEL_ONLY_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (k_cmd == CMD_WR_X) |-> !cap_en_i); // R9

    AST_WRITE_ONLY_WHEN_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (k_cmd == CMD_WR) |-> cap_en_i); // R9

endmodule

bind page_stream_seq page_stream_seq_chk #(
    .COLS   (COLS),
    .BANKS  (BANKS),
    .BANK_W (BANK_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cap_en_i    (cap_en_i),
    .cmd_cs_n_o  (cmd_cs_n_o),
    .cmd_ras_n_o (cmd_ras_n_o),
    .cmd_cas_n_o (cmd_cas_n_o),
    .cmd_we_n_o  (cmd_we_n_o),
    .cmd_ba_o    (cmd_ba_o),
    .cmd_addr_o  (cmd_addr_o),
    .cap_cs_n_o  (cap_cs_n_o),
    .cap_ras_n_o (cap_ras_n_o),
    .cap_cas_n_o (cap_cas_n_o),
    .cap_we_n_o  (cap_we_n_o),
    .cap_ba_o    (cap_ba_o),
    .cap_addr_o  (cap_addr_o)
);

// File: tb/test_page_stream_seq.sv
`timescale 1ns/1ps
module test_page_stream_seq;

    localparam int COLS   = 64;
    localparam int BANKS  = 4;
    localparam int ROW_W  = 2;
    localparam int ROWS   = 3;
    localparam int ADDR_W = 13;
    localparam int BANK_W = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic              cap_en_i = 1'b1;
    logic [1:0]        cas_lat_i = 2'd2;
    logic [1:0]        act_dly_i = 2'd1;
    logic              cmd_cs_n_o, cmd_ras_n_o, cmd_cas_n_o, cmd_we_n_o;
    logic [BANK_W-1:0] cmd_ba_o;
    logic [ADDR_W-1:0] cmd_addr_o;
    logic              cap_cs_n_o, cap_ras_n_o, cap_cas_n_o, cap_we_n_o;
    logic [BANK_W-1:0] cap_ba_o;
    logic [ADDR_W-1:0] cap_addr_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    page_stream_seq #(
        .COLS     (COLS),
        .BANKS    (BANKS),
        .ROW_W    (ROW_W),
        .NUM_ROWS (ROWS),
        .ADDR_W   (ADDR_W),
        .TIM_W    (2)
    ) i_page_stream_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .cap_en_i    (cap_en_i),
        .cas_lat_i   (cas_lat_i),
        .act_dly_i   (act_dly_i),
        .cmd_cs_n_o  (cmd_cs_n_o),
        .cmd_ras_n_o (cmd_ras_n_o),
        .cmd_cas_n_o (cmd_cas_n_o),
        .cmd_we_n_o  (cmd_we_n_o),
        .cmd_ba_o    (cmd_ba_o),
        .cmd_addr_o  (cmd_addr_o),
        .cap_cs_n_o  (cap_cs_n_o),
        .cap_ras_n_o (cap_ras_n_o),
        .cap_cas_n_o (cap_cas_n_o),
        .cap_we_n_o  (cap_we_n_o),
        .cap_ba_o    (cap_ba_o),
        .cap_addr_o  (cap_addr_o)
    );

    task automatic cmp(input string req, input string where,
                       input logic [3:0] ac, input logic [3:0] ec,
                       input logic [BANK_W-1:0] ab, input logic [BANK_W-1:0] eb,
                       input logic [ADDR_W-1:0] aa, input logic [ADDR_W-1:0] ea);
        checks++;
        if (ac !== ec || ab !== eb || aa !== ea) begin
            fails++;
            $display("FAIL %s %s: got cmd=%b ba=%0d addr=%0h, expected cmd=%b ba=%0d addr=%0h",
                     req, where, ac, ab, aa, ec, eb, ea);
        end
    endtask

    // Independent schedule model: cycle k after the start edge.
    task automatic model(input int k, input int cl, input int rcd, input bit cap,
                         output logic [3:0] c0, output logic [BANK_W-1:0] b0, output logic [ADDR_W-1:0] a0, output string q0,
                         output logic [3:0] c1, output logic [BANK_W-1:0] b1, output logic [ADDR_W-1:0] a1, output string q1);
        int p, c, n, nb, nr, pb, lead;
        lead = cl + rcd;
        if (k < lead) begin p = -1; c = COLS - lead + k; end
        else begin p = (k - lead) / COLS; c = (k - lead) % COLS; end
        n  = p + 1;
        nb = n % BANKS;
        nr = (n / BANKS) % ROWS;
        pb = (p + BANKS - 1) % BANKS;
        c0 = 4'b0111; b0 = '0; a0 = '0; q0 = "R10";
        c1 = 4'b0111; b1 = '0; a1 = '0; q1 = "R10";
        if (c == 0) begin
            c0 = 4'b0010; b0 = BANK_W'(pb); q0 = "R5";
            c1 = 4'b0010; b1 = BANK_W'(pb); q1 = "R5";
        end else if (c == COLS - lead) begin
            c0 = 4'b0011; b0 = BANK_W'(nb); a0 = ADDR_W'(nr);
            c1 = 4'b0011; b1 = BANK_W'(nb); a1 = ADDR_W'(nr);
            q0 = (k == 0) ? "R2" : "R6 R8";
            q1 = q0;
        end else if (c == COLS - cl) begin
            c0 = 4'b0101; b0 = BANK_W'(nb); q0 = "R3"; q1 = "R3";
        end else if (c == COLS - 1) begin
            c1 = cap ? 4'b0100 : 4'b1100; b1 = BANK_W'(nb);
            q1 = cap ? "R4" : "R9"; q0 = "R4";
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n   = 1'b0;
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R1: idle state after reset, with the latency inputs moving.
    task automatic check_idle(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            cas_lat_i = 2'(2 + (i % 2));
            act_dly_i = 2'(1 + (i % 3));
            #1;
            cmp("R1", "cmd idle", {cmd_cs_n_o, cmd_ras_n_o, cmd_cas_n_o, cmd_we_n_o}, 4'b0111,
                cmd_ba_o, '0, cmd_addr_o, '0);
            cmp("R1", "cap idle", {cap_cs_n_o, cap_ras_n_o, cap_cas_n_o, cap_we_n_o}, 4'b0111,
                cap_ba_o, '0, cap_addr_o, '0);
            @(negedge clk);
        end
    endtask

    // One scenario: reset, start with (cl, rcd), compare every cycle.
    // cap_mode: 0 off, 1 on, 2 alternate per page. disturb: R11 stimulus.
    task automatic run_stream(input string tag, input int cl, input int rcd,
                              input int cycles, input int cap_mode, input bit disturb);
        logic [3:0] c0, c1, g0, g1;
        logic [BANK_W-1:0] b0, b1;
        logic [ADDR_W-1:0] a0, a1;
        string q0, q1;
        int last_rd;
        last_rd = -1;
        do_reset();
        check_idle(4);
        cas_lat_i = 2'(cl);
        act_dly_i = 2'(rcd);
        start_i   = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < cycles; k++) begin
            cap_en_i = (cap_mode == 0) ? 1'b0 : (cap_mode == 1) ? 1'b1 : 1'(((k + COLS) / COLS) % 2);
            if (disturb && k == 150) begin
                start_i   = 1'b1;
                cas_lat_i = 2'(5 - cl);
                act_dly_i = 2'(rcd == 3 ? 1 : rcd + 1);
            end
            if (disturb && k == 154) start_i = 1'b0;
            #1;
            model(k, cl, rcd, cap_en_i, c0, b0, a0, q0, c1, b1, a1, q1);
            if (disturb) begin q0 = {"R11 ", q0}; q1 = {"R11 ", q1}; end
            g0 = {cmd_cs_n_o, cmd_ras_n_o, cmd_cas_n_o, cmd_we_n_o};
            g1 = {cap_cs_n_o, cap_ras_n_o, cap_cas_n_o, cap_we_n_o};
            cmp(q0, {tag, " cmd"}, g0, c0, cmd_ba_o, b0, cmd_addr_o, a0);
            cmp(q1, {tag, " cap"}, g1, c1, cap_ba_o, b1, cap_addr_o, a1);
            if (g0 == 4'b0101) begin
                if (last_rd >= 0) begin
                    checks++;
                    if (k - last_rd != COLS) begin
                        fails++;
                        $display("FAIL R7 %s read spacing: got %0d expected %0d", tag, k - last_rd, COLS);
                    end
                end
                last_rd = k;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        // R1 through R8 and R10: long run wrapping the row counter (12 pages per row cycle).
        run_stream("cl2_rcd1_on", 2, 1, 13 * COLS + 10, 1, 1'b0);
        // R9: capture off, activates and precharges keep running.
        run_stream("cl3_rcd3_off", 3, 3, 5 * COLS + 5, 0, 1'b0);
        // R4 and R9 alternating per page.
        run_stream("cl3_rcd2_alt", 3, 2, 5 * COLS + 5, 2, 1'b0);
        // R11: start pulse and latency change while running.
        run_stream("cl2_rcd3_dist", 2, 3, 4 * COLS + 5, 1, 1'b1);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: run did not complete, got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule